// File: doc/BRIEF.md
# DRAM Bank Open-Row Command Sequencer

This block sits between a request source and the command pins of one DRAM channel. It accepts one read or write request at a time; each request carries a physical byte address. It splits that address into bank, row and column fields under one of three bank-mapping schemes, chosen per request. It keeps a record, for every bank, of whether a row is open and which row that is. From that record it issues the shortest legal command sequence for the request. The sequence is a column burst alone when the row is already open, an activate and the burst when the bank is closed, and a precharge, an activate and the burst when a different row is open.

Each request moves one 64-byte block as eight column beats from a single open row. The class of the access (hit, empty bank or conflict) is reported in the cycle in which the first command of its sequence appears. Request reordering, detailed datasheet timing and the data path are outside this block.

The controller has four states. `S_IDLE` waits for a request and takes it. `S_PRE` drives a precharge, `S_ACT` drives an activate, and `S_COL` drives the column beats. The transitions are as follows:
- `S_IDLE` goes to `S_COL` on a hit, to `S_ACT` on an empty bank and to `S_PRE` on a conflict.
- `S_PRE` always goes to `S_ACT`.
- `S_ACT` always goes to `S_COL`.
- `S_COL` stays in `S_COL` until the last beat, then returns to `S_IDLE`.

Top module: `dram_row_sequencer`

## Requirements
- R1: After reset every bank is closed, `req_ready_o` is 1, `cmd_o` is 0 (no operation) and `outcome_o` is 0; the first request to any bank after reset is therefore classed as empty.
- R2: A request is taken on a rising edge where `req_valid_i` and `req_ready_o` are both 1. Its first command appears in the next cycle. `req_ready_o` stays 0 from that command through the last beat, and returns to 1 in the cycle after the last beat. While the block is busy, `req_valid_i` and the other request inputs have no effect.
- R3: For a request to a closed bank, the command sequence is activate (`cmd_o`=1, with `cmd_row_o` holding the row) followed by eight column beats. `outcome_o` is 2. After the sequence, that row is recorded as open in that bank.
- R4: For a request whose row is already open in its bank, only the eight column beats are issued, with no activate, and `outcome_o` is 1.
- R5: For a request whose bank holds a different open row, the sequence is precharge (`cmd_o`=4), then activate of the new row, then eight column beats. `outcome_o` is 3.
- R6: `outcome_o` is non-zero only in the cycle of a request's first command; it is 0 in every other cycle.
- R7: Each column beat is a read (`cmd_o`=2) for a read request and a write (`cmd_o`=3) for a write request. All beats address the same bank. Beat k carries the request's column with its three least significant bits replaced by k, for k = 0 to 7 in order.
- R8: With `map_mode_i`=0 (or 3), the address decodes as follows: bits 30:17 are the row, bits 16:14 the bank, bits 13:3 the column, and bits 2:0 the byte within the bus (ignored).
- R9: With `map_mode_i`=1, the column is formed from two parts. Bits 16:9 form its upper 8 bits and bits 5:3 its lower 3 bits. The bank is taken from bits 8:6, so 64-byte blocks at consecutive addresses land in consecutive banks. The row is bits 30:17.
- R10: With `map_mode_i`=2, the row and column fields are those of R8. The bank is address bits 16:14 XORed with the three least significant row bits (bits 19:17).
- R11: Each bank's open-row record is separate: a precharge or activate of one bank leaves the state of every other bank unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | A request is presented |
| req_ready_o | output | 1 | The block is idle and will take a request |
| req_write_i | input | 1 | 1 for a write request, 0 for a read request |
| req_addr_i | input | 31 | Physical byte address |
| map_mode_i | input | 2 | Bank mapping scheme: 0 row-interleaved, 1 block-interleaved, 2 XOR-randomized, 3 same as 0 |
| cmd_o | output | 3 | Command: 0 none, 1 activate, 2 read, 3 write, 4 precharge |
| cmd_bank_o | output | 3 | Bank addressed by the command |
| cmd_row_o | output | 14 | Row, meaningful on activate |
| cmd_col_o | output | 11 | Column, meaningful on read or write |
| outcome_o | output | 2 | Access class in the first command cycle: 1 hit, 2 empty, 3 conflict, 0 otherwise |

## Verification
The bench builds the block with its default geometry: 14 row bits, 3 bank bits, 11 column bits, 3 byte bits and 8 beats per block. With eight banks and these widths, a handful of hand-built addresses reaches every case. They produce an empty bank, a hit, a conflict and a return to an earlier bank after another bank was touched. In block mode they land consecutive 64-byte blocks in distinct banks, and in XOR mode they give two addresses with the same bank field but different row bits, which map to different banks. A reference model compares every cycle's command, bank, row, column, outcome and ready. Junk requests are held on the inputs while the block is busy, and they must leave no trace.

// File: rtl/rowseq_pkg.sv
package rowseq_pkg;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4
    } dram_cmd_e;

    typedef enum logic [1:0] {
        OC_NONE     = 2'd0,
        OC_HIT      = 2'd1,
        OC_EMPTY    = 2'd2,
        OC_CONFLICT = 2'd3
    } access_class_e;

    typedef enum logic [1:0] {
        MAP_ROW   = 2'd0,
        MAP_BLOCK = 2'd1,
        MAP_XOR   = 2'd2,
        MAP_SPARE = 2'd3
    } map_mode_e;

endpackage

// File: rtl/rowseq_addr_map.sv
module rowseq_addr_map
    import rowseq_pkg::*;
#(
    parameter int ROW_W  = 14,
    parameter int BANK_W = 3,
    parameter int COL_W  = 11,
    parameter int BYTE_W = 3,
    parameter int LCOL_W = 3,
    localparam int ADDR_W = ROW_W + BANK_W + COL_W + BYTE_W
) (
    input  logic [ADDR_W-BYTE_W-1:0] word_addr,
    input  map_mode_e                mode,
    output logic [BANK_W-1:0]        bank,
    output logic [ROW_W-1:0]         row,
    output logic [COL_W-1:0]         col
);
    localparam int HCOL_W = COL_W - LCOL_W;
    localparam int WA_W   = ADDR_W - BYTE_W;

    logic [BANK_W-1:0] flat_bank;
    logic [COL_W-1:0]  flat_col;
    logic [BANK_W-1:0] blk_bank;
    logic [COL_W-1:0]  blk_col;

    always_comb begin
        row       = word_addr[WA_W-1 -: ROW_W];
        flat_bank = word_addr[COL_W +: BANK_W];
        flat_col  = word_addr[0 +: COL_W];
        blk_bank  = word_addr[LCOL_W +: BANK_W];
        blk_col   = {word_addr[LCOL_W+BANK_W +: HCOL_W], word_addr[0 +: LCOL_W]};
        unique case (mode)
            MAP_BLOCK: begin
                bank = blk_bank;
                col  = blk_col;
            end
            MAP_XOR: begin
                bank = flat_bank ^ row[BANK_W-1:0];
                col  = flat_col;
            end
            default: begin
                bank = flat_bank;
                col  = flat_col;
            end
        endcase
    end

endmodule

// File: rtl/rowseq_bank_state.sv
module rowseq_bank_state #(
    parameter int BANK_W = 3,
    parameter int ROW_W  = 14,
    localparam int NBANK = 1 << BANK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              open_en,
    input  logic              close_en,
    input  logic [BANK_W-1:0] upd_bank,
    input  logic [ROW_W-1:0]  upd_row,
    input  logic [BANK_W-1:0] look_bank,
    output logic              look_open,
    output logic [ROW_W-1:0]  look_row
);
    logic [NBANK-1:0] is_open;
    logic [ROW_W-1:0] open_row [NBANK];

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                is_open[b]  <= 1'b0;
                open_row[b] <= '0;
            end else if (upd_bank == BANK_W'(b)) begin
                if (open_en) begin
                    is_open[b]  <= 1'b1;
                    open_row[b] <= upd_row;
                end else if (close_en) begin
                    is_open[b]  <= 1'b0;
                end
            end
        end
    end

    assign look_open = is_open[look_bank];
    assign look_row  = open_row[look_bank];

endmodule

// File: rtl/rowseq_fsm.sv
module rowseq_fsm
    import rowseq_pkg::*;
#(
    parameter int BANK_W = 3,
    parameter int ROW_W  = 14,
    parameter int COL_W  = 11,
    parameter int NBEATS = 8,
    localparam int BEAT_W = $clog2(NBEATS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [BANK_W-1:0] dec_bank,
    input  logic [ROW_W-1:0]  dec_row,
    input  logic [COL_W-1:0]  dec_col,
    input  logic              look_open,
    input  logic [ROW_W-1:0]  look_row,
    output logic              req_ready,
    output dram_cmd_e         cmd,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [ROW_W-1:0]  cmd_row,
    output logic [COL_W-1:0]  cmd_col,
    output access_class_e     outcome,
    output logic              open_en,
    output logic              close_en
);
    typedef enum logic [1:0] {S_IDLE, S_PRE, S_ACT, S_COL} seq_state_e;

    seq_state_e state_q, state_d;
    logic [BANK_W-1:0]       bank_q;
    logic [ROW_W-1:0]        row_q;
    logic [COL_W-BEAT_W-1:0] colhi_q;
    logic                    write_q;
    access_class_e           class_q, class_d;
    logic                    first_q;
    logic [BEAT_W-1:0]       beat_q;
    logic                    take;
    logic                    last_beat;

    assign take      = (state_q == S_IDLE) && req_valid;
    assign last_beat = (beat_q == BEAT_W'(NBEATS - 1));

    always_comb begin
        if (!look_open)
            class_d = OC_EMPTY;
        else if (look_row == dec_row)
            class_d = OC_HIT;
        else
            class_d = OC_CONFLICT;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (req_valid) begin
                    unique case (class_d)
                        OC_HIT:      state_d = S_COL;
                        OC_CONFLICT: state_d = S_PRE;
                        default:     state_d = S_ACT;
                    endcase
                end
            end
            S_PRE: state_d = S_ACT;
            S_ACT: state_d = S_COL;
            S_COL: if (last_beat) state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            bank_q  <= '0;
            row_q   <= '0;
            colhi_q <= '0;
            write_q <= 1'b0;
            class_q <= OC_NONE;
            first_q <= 1'b0;
            beat_q  <= '0;
        end else begin
            state_q <= state_d;
            first_q <= take;
            if (take) begin
                bank_q  <= dec_bank;
                row_q   <= dec_row;
                colhi_q <= dec_col[COL_W-1:BEAT_W];
                write_q <= req_write;
                class_q <= class_d;
                beat_q  <= '0;
            end else if (state_q == S_COL) begin
                beat_q <= last_beat ? '0 : beat_q + 1'b1;
            end
        end
    end

    always_comb begin
        req_ready = 1'b0;
        cmd       = CMD_NOP;
        open_en   = 1'b0;
        close_en  = 1'b0;
        cmd_bank  = bank_q;
        cmd_row   = row_q;
        cmd_col   = {colhi_q, beat_q};
        outcome   = first_q ? class_q : OC_NONE;
        unique case (state_q)
            S_IDLE: req_ready = 1'b1;
            S_PRE: begin
                cmd      = CMD_PRE;
                close_en = 1'b1;
            end
            S_ACT: begin
                cmd     = CMD_ACT;
                open_en = 1'b1;
            end
            S_COL: cmd = write_q ? CMD_WR : CMD_RD;
            default: req_ready = 1'b0;
        endcase
    end

endmodule

// File: rtl/dram_row_sequencer.sv
module dram_row_sequencer
    import rowseq_pkg::*;
#(
    parameter int ROW_W  = 14,
    parameter int BANK_W = 3,
    parameter int COL_W  = 11,
    parameter int BYTE_W = 3,
    parameter int LCOL_W = 3,
    parameter int NBEATS = 8,
    localparam int ADDR_W = ROW_W + BANK_W + COL_W + BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    output logic              req_ready_o,
    input  logic              req_write_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [1:0]        map_mode_i,
    output logic [2:0]        cmd_o,
    output logic [BANK_W-1:0] cmd_bank_o,
    output logic [ROW_W-1:0]  cmd_row_o,
    output logic [COL_W-1:0]  cmd_col_o,
    output logic [1:0]        outcome_o
);
    logic [BANK_W-1:0] dec_bank;
    logic [ROW_W-1:0]  dec_row;
    logic [COL_W-1:0]  dec_col;
    logic              look_open;
    logic [ROW_W-1:0]  look_row;
    logic              open_en, close_en;
    dram_cmd_e         cmd;
    access_class_e     outcome;
    logic              unused_byte_bits;

    assign unused_byte_bits = ^req_addr_i[BYTE_W-1:0];

    rowseq_addr_map #(
        .ROW_W(ROW_W), .BANK_W(BANK_W), .COL_W(COL_W),
        .BYTE_W(BYTE_W), .LCOL_W(LCOL_W)
    ) map_i (
        .word_addr (req_addr_i[ADDR_W-1:BYTE_W]),
        .mode      (map_mode_e'(map_mode_i)),
        .bank      (dec_bank),
        .row       (dec_row),
        .col       (dec_col)
    );

    rowseq_bank_state #(.BANK_W(BANK_W), .ROW_W(ROW_W)) banks_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .open_en   (open_en),
        .close_en  (close_en),
        .upd_bank  (cmd_bank_o),
        .upd_row   (cmd_row_o),
        .look_bank (dec_bank),
        .look_open (look_open),
        .look_row  (look_row)
    );

    rowseq_fsm #(
        .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W), .NBEATS(NBEATS)
    ) fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid_i),
        .req_write (req_write_i),
        .dec_bank  (dec_bank),
        .dec_row   (dec_row),
        .dec_col   (dec_col),
        .look_open (look_open),
        .look_row  (look_row),
        .req_ready (req_ready_o),
        .cmd       (cmd),
        .cmd_bank  (cmd_bank_o),
        .cmd_row   (cmd_row_o),
        .cmd_col   (cmd_col_o),
        .outcome   (outcome),
        .open_en   (open_en),
        .close_en  (close_en)
    );

    assign cmd_o     = cmd;
    assign outcome_o = outcome;

endmodule

// File: rtl/rowseq_checker.sv
module rowseq_checker #(
    parameter int BANK_W = 3,
    parameter int COL_W  = 11,
    parameter int NBEATS = 8,
    localparam int BEAT_W = $clog2(NBEATS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid_i,
    input logic              req_ready_o,
    input logic [2:0]        cmd_o,
    input logic [BANK_W-1:0] cmd_bank_o,
    input logic [COL_W-1:0]  cmd_col_o,
    input logic [1:0]        outcome_o
);
    logic is_col;
    assign is_col = (cmd_o == 3'd2) || (cmd_o == 3'd3);

    a_r2_take_starts_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_i && req_ready_o |=> cmd_o != 3'd0);

    a_r2_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_o != 3'd0 |-> !req_ready_o);

    a_r3_empty_starts_act: assert property (@(posedge clk) disable iff (!rst_n)
        outcome_o == 2'd2 |-> cmd_o == 3'd1);

    a_r3_act_then_col: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_o == 3'd1 |=> is_col && $stable(cmd_bank_o));

    a_r4_hit_starts_col: assert property (@(posedge clk) disable iff (!rst_n)
        outcome_o == 2'd1 |-> is_col);

    a_r5_conflict_starts_pre: assert property (@(posedge clk) disable iff (!rst_n)
        outcome_o == 2'd3 |-> cmd_o == 3'd4);

    a_r5_pre_then_act: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_o == 3'd4 |=> cmd_o == 3'd1 && $stable(cmd_bank_o));

    a_r6_outcome_after_take: assert property (@(posedge clk) disable iff (!rst_n)
        outcome_o != 2'd0 |-> $past(req_valid_i && req_ready_o));

    a_r7_beats_ascend: assert property (@(posedge clk) disable iff (!rst_n)
        is_col && $past(cmd_o) == cmd_o |->
            cmd_col_o[BEAT_W-1:0] == BEAT_W'($past(cmd_col_o[BEAT_W-1:0]) + 1'b1)
            && $stable(cmd_bank_o));

endmodule

bind dram_row_sequencer rowseq_checker #(
    .BANK_W(BANK_W), .COL_W(COL_W), .NBEATS(NBEATS)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid_i (req_valid_i),
    .req_ready_o (req_ready_o),
    .cmd_o       (cmd_o),
    .cmd_bank_o  (cmd_bank_o),
    .cmd_col_o   (cmd_col_o),
    .outcome_o   (outcome_o)
);

// File: tb/dram_row_sequencer_tb.sv
module dram_row_sequencer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid_i = 1'b0;
    logic        req_ready_o;
    logic        req_write_i = 1'b0;
    logic [30:0] req_addr_i = '0;
    logic [1:0]  map_mode_i = '0;
    logic [2:0]  cmd_o;
    logic [2:0]  cmd_bank_o;
    logic [13:0] cmd_row_o;
    logic [10:0] cmd_col_o;
    logic [1:0]  outcome_o;

    always #5 clk = ~clk;

    dram_row_sequencer dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
        .req_write_i(req_write_i), .req_addr_i(req_addr_i),
        .map_mode_i(map_mode_i), .cmd_o(cmd_o), .cmd_bank_o(cmd_bank_o),
        .cmd_row_o(cmd_row_o), .cmd_col_o(cmd_col_o), .outcome_o(outcome_o)
    );

    typedef struct {
        int    cmd;
        int    bank;
        int    row;
        int    col;
        int    oc;
        string stag;
        string dtag;
    } exp_t;

    exp_t exp_q[$];
    bit   bank_open [8];
    int   bank_row  [8];
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 0;

    task automatic check(string tag, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic tick();
        exp_t e;
        bit   busy;
        @(negedge clk);
        busy = exp_q.size() > 0;
        if (busy) e = exp_q.pop_front();
        else begin
            e.cmd = 0; e.bank = 0; e.row = 0; e.col = 0; e.oc = 0;
            e.stag = "R2"; e.dtag = "R2";
        end
        check(e.stag, "cmd", int'(cmd_o), e.cmd);
        check("R2", "ready", int'(req_ready_o), busy ? 0 : 1);
        check(busy ? e.stag : "R6", "outcome", int'(outcome_o), e.oc);
        if (busy) begin
            check(e.dtag, "bank", int'(cmd_bank_o), e.bank);
            if (e.cmd == 1) check(e.dtag, "row", int'(cmd_row_o), e.row);
            if (e.cmd == 2 || e.cmd == 3) check(e.dtag, "col", int'(cmd_col_o), e.col);
        end
    endtask

    // Reference model of one request; junk holds a bogus request while busy (R2).
    task automatic do_req(int unsigned a, bit we, int mode, bit junk);
        int    bank, row, col, first_oc;
        string dtag, stag;
        exp_t  e;
        row = int'((a / 131072) % 16384);
        if (mode == 1) begin
            bank = int'((a / 64) % 8);
            col  = int'(((a / 512) % 256) * 8 + (a / 8) % 8);
            dtag = "R9";
        end else if (mode == 2) begin
            bank = int'((a / 16384) % 8) ^ (row % 8);
            col  = int'((a / 8) % 2048);
            dtag = "R10";
        end else begin
            bank = int'((a / 16384) % 8);
            col  = int'((a / 8) % 2048);
            dtag = "R8";
        end
        e.bank = bank; e.row = row; e.dtag = dtag; e.col = 0;
        if (!bank_open[bank]) begin
            stag = "R3"; first_oc = 2;
            e.cmd = 1; e.oc = 2; e.stag = stag; exp_q.push_back(e);
        end else if (bank_row[bank] == row) begin
            stag = "R4"; first_oc = 1;
        end else begin
            stag = "R5"; first_oc = 3;
            e.cmd = 4; e.oc = 3; e.stag = stag; exp_q.push_back(e);
            e.cmd = 1; e.oc = 0; exp_q.push_back(e);
        end
        for (int k = 0; k < 8; k++) begin
            e.cmd  = we ? 3 : 2;
            e.col  = (col / 8) * 8 + k;
            e.oc   = (k == 0 && stag == "R4") ? first_oc : 0;
            e.stag = "R7";
            exp_q.push_back(e);
        end
        bank_open[bank] = 1;
        bank_row[bank]  = row;
        req_valid_i = 1'b1;
        req_write_i = we;
        req_addr_i  = a[30:0];
        map_mode_i  = mode[1:0];
        tick();
        req_valid_i = 1'b0;
        while (exp_q.size() > 0) begin
            if (junk) begin
                req_valid_i = 1'b1;
                req_write_i = ~we;
                req_addr_i  = 31'h5555_1234;
                map_mode_i  = 2'd2;
            end
            tick();
        end
        req_valid_i = 1'b0;
        tick();
    endtask

    function automatic int unsigned flat(int row, int bank, int col, int byt);
        return (row * 131072) + (bank * 16384) + (col * 8) + byt;
    endfunction

    initial begin
        for (int b = 0; b < 8; b++) begin
            bank_open[b] = 0;
            bank_row[b]  = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        tick(); // R1 idle state after reset

        // R8: row-interleaved; R3 empty, R4 hit, R5 conflict
        do_req(flat(100, 2, 37, 5), 0, 0, 0);
        do_req(flat(100, 2, 1200, 0), 1, 0, 1);
        do_req(flat(101, 2, 9, 3), 0, 0, 0);
        // R11: another bank then return to bank 2 row 101 -> hit
        do_req(flat(7, 5, 2047, 7), 1, 0, 0);
        do_req(flat(101, 2, 640, 0), 0, 3, 0);
        do_req(flat(7, 5, 16, 0), 0, 3, 1);
        // R9: consecutive 64-byte blocks map to consecutive banks
        for (int k = 0; k < 4; k++)
            do_req(32'(200 * 131072 + 3 * 512 + k * 64), k[0], 1, 0);
        do_req(32'(200 * 131072 + 3 * 512 + 64 + 16), 0, 1, 0);
        do_req(32'(201 * 131072 + 70 * 512 + 64), 1, 1, 0);
        // R10: same bank field, different low row bits -> different banks
        do_req(flat(300, 1, 55, 0), 0, 2, 0);
        do_req(flat(301, 1, 55, 0), 0, 2, 0);
        do_req(flat(300, 1, 100, 0), 1, 2, 1);
        do_req(flat(308, 1, 0, 0), 0, 2, 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule